// File: doc/BRIEF.md
# Block-Wise CRC Signature Combiner

This block builds an integrity signature over a region of word-addressed memory one 64-byte block at a time. Each block of sixteen 32-bit words gets its own CRC-32, which always starts from all ones. The CRC uses polynomial 0x04C11DB7, takes each word most significant bit first, and applies no output reflection and no final XOR. The finished block CRC is folded into a running signature. The signature starts at 0xFFFFFFFF, is shifted right by eight bits, and is then XORed with the block CRC. Because the shift happens before every fold, the result depends on the order of the blocks.

Work is paced by the user. A `start` pulse loads the region's first word address and its length in blocks, and it resets the signature. Each later `step` pulse processes exactly one block and then returns the block to idle. Between steps the shared memory port is free for other users, so a long check can be spread over time and interleaved with other traffic.

Top module: `blk_crc_sig`

## Requirements
- R1: A `start` pulse sets `signature` to 0xFFFFFFFF and clears `busy` one cycle later. `done` then equals 1 only if `num_blocks` was 0.
- R2: A start with `num_blocks` = 0 raises `done` on the next cycle and leaves `signature` at 0xFFFFFFFF. A later step causes no memory reads.
- R3: When the block is idle, not done and has blocks left, a `step` pulse raises `busy` on the next cycle. The block then issues exactly 16 reads at consecutive word addresses, starting at the start address plus 16 times the number of blocks already processed.
- R4: Each block CRC starts from 0xFFFFFFFF, uses polynomial 0x04C11DB7, and feeds the 16 words in address order, MSB first. It has no reflection and no final XOR.
- R5: At the end of a block, `signature` becomes (`signature` >> 8) XOR block CRC, and `busy` falls in the same cycle. `signature` changes at no other time except on `start`.
- R6: A `step` that arrives while `busy` is high has no effect: no extra reads and no extra block.
- R7: `done` rises in the cycle the last block is merged. It stays high, and further steps are ignored, until the next `start`.
- R8: `mem_rd_en` is high only while `busy` is high, and `done` and `busy` are never high together.
- R9: Exchanging the contents of two blocks in the region changes the final signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load region and reset signature (one-cycle pulse) |
| base_addr | input | AW (12) | First word address of the region |
| num_blocks | input | LW (8) | Region length in 16-word blocks |
| step | input | 1 | Request to process one block |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW (12) | Memory word address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the strobe |
| signature | output | 32 | Running merged signature |
| done | output | 1 | All blocks merged |
| busy | output | 1 | A block is in progress |

## Verification
The checker watches the cycle-level rules on every clock. It checks that reads stay inside busy windows and that each block issues at most sixteen reads with consecutively increasing addresses. It also checks that the signature stays frozen while the block is idle, that done is held until restart, and the zero-length start. The CRC arithmetic, the merge formula, the ignored mid-block step and the order sensitivity of the signature are shown only by the bench. It compares the signature after each block with an independent model over random and directed regions, including a run where two blocks are swapped.

// File: rtl/crc_sig_pkg.sv
package crc_sig_pkg;
    localparam int          DATA_W        = 32;
    localparam int          WORDS_PER_BLK = 16;
    localparam int          WCNT_W        = $clog2(WORDS_PER_BLK);
    localparam logic [31:0] CRC_POLY      = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
    localparam logic [31:0] SIG_SEED      = 32'hFFFF_FFFF;
    localparam int          SIG_SHIFT     = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RUN   = 2'd1,
        PH_MERGE = 2'd2
    } phase_e;

    // Fold one whole word into the CRC, MSB first, non-reflected
    function automatic logic [31:0] crc_fold_word(input logic [31:0] c, input logic [31:0] w);
        logic [31:0] r;
        r = c ^ w;
        for (int k = 0; k < DATA_W; k++) begin
            r = r[31] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

    function automatic logic [31:0] sig_fold(input logic [31:0] s, input logic [31:0] blk);
        return (s >> SIG_SHIFT) ^ blk;
    endfunction
endpackage

// File: rtl/blk_word_fetch.sv
module blk_word_fetch
    import crc_sig_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          go,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr
);
    logic [AW-1:0]     addr_q;
    logic [WCNT_W-1:0] cnt_q;
    logic              issuing_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            cnt_q     <= '0;
            issuing_q <= 1'b0;
        end else if (load) begin
            addr_q    <= load_addr;
            cnt_q     <= '0;
            issuing_q <= 1'b0;
        end else if (go) begin
            cnt_q     <= '0;
            issuing_q <= 1'b1;
        end else if (issuing_q) begin
            addr_q <= addr_q + 1'b1;
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == WCNT_W'(WORDS_PER_BLK - 1)) issuing_q <= 1'b0;
        end
    end

    assign rd_en   = issuing_q;
    assign rd_addr = addr_q;
endmodule

// File: rtl/blk_crc_engine.sv
module blk_crc_engine
    import crc_sig_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        word_vld,
    input  logic        first,
    input  logic [31:0] word,
    output logic [31:0] crc
);
    logic [31:0] crc_q;
    logic [31:0] base;

    assign base = first ? CRC_SEED : crc_q;

    always_ff @(posedge clk) begin
        if (rst)           crc_q <= CRC_SEED;
        else if (word_vld) crc_q <= crc_fold_word(base, word);
    end

    assign crc = crc_q;
endmodule

// File: rtl/blk_sig_accum.sv
module blk_sig_accum
    import crc_sig_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        merge,
    input  logic [31:0] blk_crc,
    output logic [31:0] sig
);
    logic [31:0] sig_q;

    always_ff @(posedge clk) begin
        if (rst || clear) sig_q <= SIG_SEED;
        else if (merge)   sig_q <= sig_fold(sig_q, blk_crc);
    end

    assign sig = sig_q;
endmodule

// File: rtl/blk_crc_sig.sv
module blk_crc_sig
    import crc_sig_pkg::*;
#(
    parameter int AW = 12,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [LW-1:0] num_blocks,
    input  logic          step,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [31:0]   mem_rd_data,
    output logic [31:0]   signature,
    output logic          done,
    output logic          busy
);
    phase_e            phase_q;
    logic [LW-1:0]     left_q;
    logic              done_q;
    logic              vld_q;
    logic [WCNT_W-1:0] rcv_q;
    logic              go;
    logic              merge;
    logic [31:0]       blk_crc;

    assign go    = step && !start && (phase_q == PH_IDLE) && !done_q && (left_q != '0);
    assign merge = (phase_q == PH_MERGE) && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            left_q  <= '0;
            done_q  <= 1'b0;
            vld_q   <= 1'b0;
            rcv_q   <= '0;
        end else if (start) begin
            phase_q <= PH_IDLE;
            left_q  <= num_blocks;
            done_q  <= (num_blocks == '0);
            vld_q   <= 1'b0;
            rcv_q   <= '0;
        end else begin
            vld_q <= mem_rd_en;
            unique case (phase_q)
                PH_IDLE: begin
                    if (go) begin
                        phase_q <= PH_RUN;
                        rcv_q   <= '0;
                    end
                end
                PH_RUN: begin
                    if (vld_q) begin
                        rcv_q <= rcv_q + 1'b1;
                        if (rcv_q == WCNT_W'(WORDS_PER_BLK - 1)) phase_q <= PH_MERGE;
                    end
                end
                PH_MERGE: begin
                    phase_q <= PH_IDLE;
                    left_q  <= left_q - 1'b1;
                    done_q  <= (left_q == LW'(1));
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    blk_word_fetch #(.AW(AW)) fetch_i (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_addr(base_addr),
        .go       (go),
        .rd_en    (mem_rd_en),
        .rd_addr  (mem_rd_addr)
    );

    blk_crc_engine engine_i (
        .clk     (clk),
        .rst     (rst),
        .word_vld(vld_q && (phase_q == PH_RUN)),
        .first   (rcv_q == '0),
        .word    (mem_rd_data),
        .crc     (blk_crc)
    );

    blk_sig_accum accum_i (
        .clk    (clk),
        .rst    (rst),
        .clear  (start),
        .merge  (merge),
        .blk_crc(blk_crc),
        .sig    (signature)
    );

    assign done = done_q;
    assign busy = (phase_q != PH_IDLE);
endmodule

// File: rtl/blk_crc_sig_chk.sv
module blk_crc_sig_chk #(
    parameter int AW = 12,
    parameter int LW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [LW-1:0] num_blocks,
    input logic          step,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_rd_addr,
    input logic [31:0]   signature,
    input logic          done,
    input logic          busy
);
    logic [5:0] rd_cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !busy) rd_cnt_q <= '0;
        else if (mem_rd_en) rd_cnt_q <= rd_cnt_q + 1'b1;
    end

    // R8
    rd_in_busy_chk: assert property (@(posedge clk) disable iff (rst) mem_rd_en |-> busy);
    // R8
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst) !(done && busy));
    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst) (done && !start) |=> done);
    // R2
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        (start && num_blocks == '0) |=> (done && signature == 32'hFFFF_FFFF));
    // R1
    start_init_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (signature == 32'hFFFF_FFFF && !busy));
    // R5
    sig_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(signature));
    // R3
    busy_from_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> (!busy || $past(step)));
    // R3
    addr_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && busy && !start) |=> (!mem_rd_en || mem_rd_addr == $past(mem_rd_addr) + 1'b1));
    // R3
    rd_count_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_rd_en) |-> (rd_cnt_q < 6'd16));
endmodule

bind blk_crc_sig blk_crc_sig_chk #(.AW(AW), .LW(LW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .num_blocks (num_blocks),
    .step       (step),
    .mem_rd_en  (mem_rd_en),
    .mem_rd_addr(mem_rd_addr),
    .signature  (signature),
    .done       (done),
    .busy       (busy)
);

// File: tb/blk_crc_sig_tb_top.sv
`timescale 1ns/1ps
module blk_crc_sig_tb_top;
    localparam int AW = 12;
    localparam int LW = 8;
    localparam int MEMD = 1024;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [LW-1:0] num_blocks = '0;
    logic          step = 1'b0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [31:0]   mem_rd_data;
    logic [31:0]   signature;
    logic          done;
    logic          busy;

    logic [31:0] mem [MEMD];
    int unsigned rd_total = 0;
    int unsigned rd_sum = 0;
    int unsigned stray = 0;
    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    blk_crc_sig #(.AW(AW), .LW(LW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .num_blocks(num_blocks), .step(step), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .signature(signature), .done(done), .busy(busy)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem[mem_rd_addr % MEMD];
            rd_total    <= rd_total + 1;
            rd_sum      <= rd_sum + mem_rd_addr;
            if (!busy) stray <= stray + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bench model: bit-serial CRC, one data bit per iteration
    function automatic logic [31:0] ref_blk_crc(input int unsigned base);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int w = 0; w < 16; w++) begin
            logic [31:0] d = mem[(base + w) % MEMD];
            for (int b = 31; b >= 0; b--) begin
                logic fb = c[31] ^ d[b];
                c = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        end
        return c;
    endfunction

    task automatic run_region(input int unsigned base, input int n, input bit poke, output logic [31:0] result);
        logic [31:0] exp = 32'hFFFF_FFFF;
        @(negedge clk);
        base_addr = AW'(base); num_blocks = LW'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(signature == 32'hFFFF_FFFF, "R1 signature after start", signature, 32'hFFFF_FFFF);
        check(!busy && (done == (n == 0)), "R1/R2 flags after start", {30'd0, done, busy}, {31'd0, n == 0});
        for (int b = 0; b < n; b++) begin
            int unsigned r0 = rd_total;
            int unsigned s0 = rd_sum;
            int unsigned blk = base + 16 * b;
            step = 1'b1; @(negedge clk); step = 1'b0;
            check(busy, "R3 busy after step", {31'd0, busy}, 32'd1);
            if (poke) begin
                repeat (4) @(negedge clk);
                step = 1'b1; @(negedge clk); step = 1'b0;
            end
            while (busy) @(negedge clk);
            exp = (exp >> 8) ^ ref_blk_crc(blk);
            check(rd_total - r0 == 16, "R3 reads per block", rd_total - r0, 32'd16);
            check(rd_sum - s0 == 16 * blk + 120, "R3 read addresses", rd_sum - s0, 16 * blk + 120);
            check(signature == exp, "R4/R5 signature", signature, exp);
            check(done == (b == n - 1), "R7 done timing", {31'd0, done}, {31'd0, b == n - 1});
            if (poke) begin
                repeat (3) @(negedge clk);
                check(!busy && rd_total - r0 == 16, "R6 step while busy ignored", rd_total - r0, 32'd16);
            end
        end
        begin
            int unsigned r1 = rd_total;
            logic [31:0] s1 = signature;
            step = 1'b1; @(negedge clk); step = 1'b0;
            repeat (25) @(negedge clk);
            check(rd_total == r1 && signature == s1 && done && !busy,
                  "R7/R2 step after done ignored", signature, s1);
        end
        result = signature;
    endtask

    initial begin
        logic [31:0] sa, sb, tmp;
        void'($urandom(32'd7));
        for (int i = 0; i < MEMD; i++) mem[i] = $urandom;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mem_rd_en, "R8 reset state", {29'd0, mem_rd_en, done, busy}, 32'd0);

        run_region(0, 0, 1'b0, tmp);
        check(tmp == 32'hFFFF_FFFF, "R2 zero length signature", tmp, 32'hFFFF_FFFF);

        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        run_region(0, 1, 1'b0, tmp);
        run_region(0, 1, 1'b1, tmp);

        for (int t = 0; t < 6; t++) begin
            int n = 1 + ($urandom % 4);
            int unsigned base = $urandom % (MEMD - 16 * n);
            run_region(base, n, t[0], tmp);
        end

        run_region(100, 2, 1'b0, sa);
        for (int i = 0; i < 16; i++) begin
            logic [31:0] x = mem[100 + i];
            mem[100 + i] = mem[116 + i];
            mem[116 + i] = x;
        end
        run_region(100, 2, 1'b0, sb);
        check(sa != sb, "R9 swapped blocks change signature", sb, sa);
        check(stray == 0, "R8 reads outside busy", stray, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule